// File: doc/BRIEF.md
# Bit-Bang Target Clock and Reset Sequencer

This block drives a slow clock line, a reset line and a serial data line toward a target circuit, and it samples one serial data line coming back. A host sends short commands over a valid/ready channel, and each command carries an opcode and an argument. With these commands the host sets the clock half period, runs the clock freely, emits an exact number of clock pulses, stops the clock, sets the reset line or pulses it, chooses the sampling edge and schedules the next output bit. A free-running prescaler divides the system clock into ticks. The clock half period is counted in those ticks. With the default divider and a 125 MHz system clock, the output clock covers the 1 Hz to 1000 Hz range.

Commands that act on the target lines are held in a queue. The queue only drains while the generated clock is running. Work posted while the clock is stopped therefore waits and then executes in order once the clock restarts. Clock-control commands skip the queue so that they can always restart the clock. Each sampled input bit goes back on a response stream, together with the index of the clock pulse it was taken on.

Top module: `bitbang_seq`

## Requirements
- R1: After reset the clock, reset and data outputs are low, no response is valid, and cmd_ready is high for every opcode.
- R2: Opcode 0 sets the half period H (the argument, 0 read as 1) in prescaler ticks of PRESC_DIV system cycles. Every high phase of the generated clock then lasts exactly H*PRESC_DIV system cycles. Opcode 1 makes the clock run without end.
- R3: Opcode 2 with argument N>0 produces exactly N rising edges. After the falling edge of the last pulse the clock stays low.
- R4: Opcode 3, or opcode 2 with N=0, stops the clock. If the clock is low it stops at once with no further edge. If the clock is high it stops after the current falling edge.
- R5: Opcodes 5, 6 and 7 are queued. An entry starts only while the clock runs, and entries execute in arrival order. While the clock is stopped they have no effect on the reset or data outputs.
- R6: The queue holds QDEPTH entries. When it is full, cmd_ready is low for opcodes 5 to 7 and stays high for opcodes 0 to 4.
- R7: Opcode 5 sets the reset output to arg[0]. Opcode 6 drives the reset output high for L ticks (L = argument, 0 read as 1) and then low. The high time lies between (L-1)*PRESC_DIV+1 and L*PRESC_DIV system cycles.
- R8: Opcode 4 selects the sampling edge: arg[0]=0 selects rising and arg[0]=1 selects falling. Each sampling edge yields one response, with rsp_bit equal to tgt_din at that edge. The response is valid one cycle after the clock output changes.
- R9: Opcode 7 sets the data output to arg[0] at the next launch edge, which is the edge opposite the sampling edge. The output changes one system cycle after the clock output does, and the queue head waits for that edge.
- R10: rsp_idx equals the number of rising edges since reset that came before the sampled pulse, modulo 2^IDX_W. A falling-edge sample reports the same index as the rising edge of its own pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken on this edge when valid |
| cmd_op | input | 3 | Opcode |
| cmd_arg | input | ARG_W | Command argument |
| rsp_valid | output | 1 | One-cycle strobe for a sampled bit |
| rsp_bit | output | 1 | Sampled input value |
| rsp_idx | output | IDX_W | Index of the clock pulse that was sampled |
| tgt_clk | output | 1 | Generated target clock |
| tgt_rst | output | 1 | Target reset line |
| tgt_dout | output | 1 | Serial data toward the target |
| tgt_din | input | 1 | Serial data from the target |

## Verification
The bench goes after the edges of the pulse counter. A counter that is off by one shows up as an extra or missing rising edge. A zero count that still starts the clock shows up as edges on an idle line. The bench also sends queued commands while the clock is stopped. A design that does not gate the queue on the running clock changes reset or data too early. It then fills the queue to its limit: an off-by-one full flag either drops a command or stalls the control opcodes. Finally, it changes the sampling edge, which exposes a data output launched on the wrong edge and pulse indices that shift by one on falling-edge samples.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

   typedef enum logic [2:0] {
      OP_HALF     = 3'd0,
      OP_RUN      = 3'd1,
      OP_PULSES   = 3'd2,
      OP_STOP     = 3'd3,
      OP_EDGE     = 3'd4,
      OP_RSTLVL   = 3'd5,
      OP_RSTPULSE = 3'd6,
      OP_DOUT     = 3'd7
   } bbs_op_e;

   typedef enum logic [1:0] {
      CK_IDLE  = 2'd0,
      CK_FREE  = 2'd1,
      CK_COUNT = 2'd2
   } ck_mode_e;

   typedef enum logic {
      EX_IDLE = 1'b0,
      EX_RSTP = 1'b1
   } ex_state_e;

   function automatic logic op_is_queued(bbs_op_e op);
      return (op == OP_RSTLVL) || (op == OP_RSTPULSE) || (op == OP_DOUT);
   endfunction

endpackage

// File: rtl/bbs_prescale.sv
module bbs_prescale #(
   parameter int DIV = 62500
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("bbs_prescale: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_pass
         assign tick_o = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q  <= '0;
            end else if (cnt_q == CW'(DIV - 1)) begin
               cnt_q  <= '0;
            end else begin
               cnt_q  <= cnt_q + 1'b1;
            end
         end
         assign tick_o = (cnt_q == CW'(DIV - 1));

         tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> !tick_o);
      end
   endgenerate
endmodule

// File: rtl/bbs_fifo.sv
module bbs_fifo #(
   parameter int W     = 19,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] data_i,
   input  logic         pop_i,
   output logic [W-1:0] data_o,
   output logic         empty_o,
   output logic         full_o
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("bbs_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0]  mem_q [DEPTH];
   logic [AW-1:0] wr_q, rd_q;
   logic [CW-1:0] cnt_q;

   function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (push_i) mem_q[wr_q] <= data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_i) wr_q <= bump(wr_q);
         if (pop_i)  rd_q <= bump(rd_q);
         case ({push_i, pop_i})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign data_o  = mem_q[rd_q];
   assign empty_o = (cnt_q == '0);
   assign full_o  = (cnt_q == CW'(DEPTH));

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o);
   // R5
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o);
endmodule

// File: rtl/bbs_clkgen.sv
module bbs_clkgen
   import bbs_pkg::*;
#(
   parameter int HALF_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [HALF_W-1:0] half_i,
   input  logic              run_i,
   input  logic              count_i,
   input  logic [CNT_W-1:0]  count_n_i,
   output logic              clk_o,
   output logic              rise_o,
   output logic              fall_o,
   output logic              running_o
);
   ck_mode_e          mode_q;
   logic              stop_pend_q;
   logic [CNT_W-1:0]  left_q;
   logic [HALF_W-1:0] half_cnt_q;
   logic [HALF_W-1:0] half_eff;
   logic              clk_q, rise_q, fall_q;

   assign half_eff = (half_i == '0) ? HALF_W'(1) : half_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q      <= CK_IDLE;
         stop_pend_q <= 1'b0;
         left_q      <= '0;
         half_cnt_q  <= '0;
         clk_q       <= 1'b0;
         rise_q      <= 1'b0;
         fall_q      <= 1'b0;
      end else begin
         rise_q <= 1'b0;
         fall_q <= 1'b0;
         if (run_i) begin
            mode_q      <= CK_FREE;
            stop_pend_q <= 1'b0;
         end else if (count_i) begin
            if (count_n_i == '0) begin
               if (!clk_q) begin
                  mode_q      <= CK_IDLE;
                  half_cnt_q  <= '0;
                  stop_pend_q <= 1'b0;
               end else begin
                  stop_pend_q <= 1'b1;
               end
            end else begin
               mode_q      <= CK_COUNT;
               left_q      <= count_n_i;
               stop_pend_q <= 1'b0;
            end
         end else if (mode_q != CK_IDLE && tick_i) begin
            if (half_cnt_q >= half_eff - HALF_W'(1)) begin
               half_cnt_q <= '0;
               clk_q      <= !clk_q;
               if (!clk_q) begin
                  rise_q <= 1'b1;
                  if (mode_q == CK_COUNT) begin
                     left_q <= left_q - 1'b1;
                     if (left_q == CNT_W'(1)) stop_pend_q <= 1'b1;
                  end
               end else begin
                  fall_q <= 1'b1;
                  if (stop_pend_q) begin
                     mode_q      <= CK_IDLE;
                     stop_pend_q <= 1'b0;
                  end
               end
            end else begin
               half_cnt_q <= half_cnt_q + 1'b1;
            end
         end
      end
   end

   assign clk_o     = clk_q;
   assign rise_o    = rise_q;
   assign fall_o    = fall_q;
   assign running_o = (mode_q != CK_IDLE);

   // R2
   clk_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_q != $past(clk_q)) |-> $past(tick_i));
   // R4
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == CK_IDLE && !run_i && !count_i) |=> !rise_o);
   // R3
   count_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == CK_COUNT && left_q == '0 && !run_i && !count_i) |=> !rise_o);
endmodule

// File: rtl/bitbang_seq.sv
module bitbang_seq
   import bbs_pkg::*;
#(
   parameter int PRESC_DIV = 62500,
   parameter int ARG_W     = 16,
   parameter int QDEPTH    = 16,
   parameter int IDX_W     = 8,
   parameter int DEF_HALF  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [2:0]       cmd_op,
   input  logic [ARG_W-1:0] cmd_arg,
   output logic             rsp_valid,
   output logic             rsp_bit,
   output logic [IDX_W-1:0] rsp_idx,
   output logic             tgt_clk,
   output logic             tgt_rst,
   output logic             tgt_dout,
   input  logic             tgt_din
);
   localparam int QW = ARG_W + 3;

   generate
      if (ARG_W < 2 || IDX_W < 1 || QDEPTH < 2 || PRESC_DIV < 1) begin : g_bad_param
         $error("bitbang_seq: parameter out of range");
      end
   endgenerate

   bbs_op_e          op_in;
   logic             queued_in, accept;
   logic             tick, rise, fall, running;
   logic             q_empty, q_full, q_pop, q_push;
   logic [QW-1:0]    q_head;
   bbs_op_e          head_op;
   logic [ARG_W-1:0] head_arg, len_eff;
   logic             launch_stb, sample_stb;

   logic [ARG_W-1:0] half_q;
   logic             edge_fall_q;
   ex_state_e        ex_q;
   logic [ARG_W-1:0] rp_cnt_q;
   logic             rst_q, dout_q;
   logic [IDX_W-1:0] rise_cnt_q;
   logic             rsp_valid_q, rsp_bit_q;
   logic [IDX_W-1:0] rsp_idx_q;

   assign op_in     = bbs_op_e'(cmd_op);
   assign queued_in = op_is_queued(op_in);
   assign cmd_ready = queued_in ? !q_full : 1'b1;
   assign accept    = cmd_valid && cmd_ready;
   assign q_push    = accept && queued_in;

   bbs_prescale #(.DIV(PRESC_DIV)) presc_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   bbs_clkgen #(.HALF_W(ARG_W), .CNT_W(ARG_W)) ckgen_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .half_i    (half_q),
      .run_i     (accept && op_in == OP_RUN),
      .count_i   (accept && (op_in == OP_PULSES || op_in == OP_STOP)),
      .count_n_i ((op_in == OP_STOP) ? '0 : cmd_arg),
      .clk_o     (tgt_clk),
      .rise_o    (rise),
      .fall_o    (fall),
      .running_o (running)
   );

   bbs_fifo #(.W(QW), .DEPTH(QDEPTH)) queue_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (q_push),
      .data_i  ({cmd_op, cmd_arg}),
      .pop_i   (q_pop),
      .data_o  (q_head),
      .empty_o (q_empty),
      .full_o  (q_full)
   );

   assign head_op    = bbs_op_e'(q_head[QW-1:ARG_W]);
   assign head_arg   = q_head[ARG_W-1:0];
   assign len_eff    = (head_arg == '0) ? ARG_W'(1) : head_arg;
   assign launch_stb = edge_fall_q ? rise : fall;
   assign sample_stb = edge_fall_q ? fall : rise;

   always_comb begin
      q_pop = 1'b0;
      if (!q_empty) begin
         if (ex_q == EX_IDLE) begin
            if (head_op == OP_RSTLVL && running) q_pop = 1'b1;
            if (head_op == OP_DOUT && launch_stb) q_pop = 1'b1;
         end else if (tick && rp_cnt_q >= len_eff - ARG_W'(1)) begin
            q_pop = 1'b1;
         end
      end
   end

   // control registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q      <= ARG_W'(DEF_HALF);
         edge_fall_q <= 1'b0;
      end else if (accept) begin
         if (op_in == OP_HALF) half_q      <= cmd_arg;
         if (op_in == OP_EDGE) edge_fall_q <= cmd_arg[0];
      end
   end

   // queue executor
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ex_q     <= EX_IDLE;
         rp_cnt_q <= '0;
         rst_q    <= 1'b0;
         dout_q   <= 1'b0;
      end else begin
         if (ex_q == EX_IDLE) begin
            if (q_pop && head_op == OP_RSTLVL) rst_q  <= head_arg[0];
            if (q_pop && head_op == OP_DOUT)   dout_q <= head_arg[0];
            if (!q_empty && running && head_op == OP_RSTPULSE) begin
               ex_q     <= EX_RSTP;
               rst_q    <= 1'b1;
               rp_cnt_q <= '0;
            end
         end else if (tick) begin
            if (rp_cnt_q >= len_eff - ARG_W'(1)) begin
               rst_q <= 1'b0;
               ex_q  <= EX_IDLE;
            end else begin
               rp_cnt_q <= rp_cnt_q + 1'b1;
            end
         end
      end
   end

   // sampler
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_cnt_q  <= '0;
         rsp_valid_q <= 1'b0;
         rsp_bit_q   <= 1'b0;
         rsp_idx_q   <= '0;
      end else begin
         if (rise) rise_cnt_q <= rise_cnt_q + 1'b1;
         rsp_valid_q <= sample_stb;
         if (sample_stb) begin
            rsp_bit_q <= tgt_din;
            rsp_idx_q <= edge_fall_q ? rise_cnt_q - 1'b1 : rise_cnt_q;
         end
      end
   end

   assign tgt_rst   = rst_q;
   assign tgt_dout  = dout_q;
   assign rsp_valid = rsp_valid_q;
   assign rsp_bit   = rsp_bit_q;
   assign rsp_idx   = rsp_idx_q;

   // R9
   dout_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_dout != $past(tgt_dout)) |-> $past(launch_stb));
   // R8
   rsp_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(sample_stb));
   // R5
   queue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && ex_q == EX_IDLE) |=> $stable(tgt_rst));
   // R6
   ctrl_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !queued_in) |-> cmd_ready);
endmodule

// File: tb/bitbang_seq_tb.sv
module bitbang_seq_tb_top;
   import bbs_pkg::*;

   localparam int P     = 2;
   localparam int ARG_W = 16;
   localparam int IDX_W = 8;
   localparam int QD    = 16;

   typedef struct packed {
      logic [15:0] half;
      logic [7:0]  n;
      logic        fall;
      logic [7:0]  pat;
   } vec_t;

   localparam int NV = 5;
   localparam vec_t VEC [NV] = '{
      '{16'd1, 8'd5, 1'b0, 8'hA5},
      '{16'd2, 8'd3, 1'b1, 8'h3C},
      '{16'd3, 8'd8, 1'b0, 8'hF0},
      '{16'd1, 8'd1, 1'b1, 8'h01},
      '{16'd4, 8'd2, 1'b0, 8'h02}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic cmd_ready;
   logic [2:0] cmd_op = 3'd0;
   logic [ARG_W-1:0] cmd_arg = '0;
   logic rsp_valid, rsp_bit;
   logic [IDX_W-1:0] rsp_idx;
   logic tgt_clk, tgt_rst, tgt_dout, tgt_din;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // monitor state
   logic [7:0] exp_pat = 8'h00;
   int samp_k = 0, base = 0, mon_bad = 0, dout_bad = 0;
   int rise_total = 0, hi_cnt = 0, last_hi = 0, rst_hi = 0, last_rst_hi = 0;
   int since_rise = 100, since_fall = 100;
   bit cur_fall = 0;
   logic prev_clk = 0, prev_rst = 0, prev_dout = 0;

   always #4 clk = !clk;

   assign tgt_din = exp_pat[samp_k[2:0]];

   bitbang_seq #(.PRESC_DIV(P), .ARG_W(ARG_W), .QDEPTH(QD), .IDX_W(IDX_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_arg(cmd_arg), .rsp_valid(rsp_valid), .rsp_bit(rsp_bit),
      .rsp_idx(rsp_idx), .tgt_clk(tgt_clk), .tgt_rst(tgt_rst), .tgt_dout(tgt_dout),
      .tgt_din(tgt_din)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (tgt_clk && !prev_clk) begin rise_total++; since_rise = 0; end
         else since_rise++;
         if (!tgt_clk && prev_clk) begin last_hi = hi_cnt; hi_cnt = 0; since_fall = 0; end
         else since_fall++;
         if (tgt_clk) hi_cnt++;
         if (tgt_rst) rst_hi++;
         else if (prev_rst) begin last_rst_hi = rst_hi; rst_hi = 0; end
         if (tgt_dout !== prev_dout)
            if ((cur_fall ? since_rise : since_fall) != 1) dout_bad++;
         if (rsp_valid) begin
            if (rsp_bit !== exp_pat[samp_k[2:0]] || rsp_idx !== IDX_W'(base + samp_k))
               mon_bad++;
            samp_k++;
         end
         prev_clk = tgt_clk; prev_rst = tgt_rst; prev_dout = tgt_dout;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input int act, input int exp);
      chk(act == exp, req, act, exp);
   endtask

   task automatic send(input logic [2:0] op, input logic [ARG_W-1:0] arg);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int r0;
      cmd_op = OP_RSTLVL;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      chk_eq("R1 clk", int'(tgt_clk), 0);
      chk_eq("R1 rst", int'(tgt_rst), 0);
      chk_eq("R1 dout", int'(tgt_dout), 0);
      chk_eq("R1 rsp_valid", int'(rsp_valid), 0);
      chk_eq("R1 ready", int'(cmd_ready), 1);

      // table walk: R2 R3 R8 R10
      for (int v = 0; v < NV; v++) begin
         send(OP_HALF, VEC[v].half);
         send(OP_EDGE, ARG_W'(VEC[v].fall));
         cur_fall = VEC[v].fall;
         exp_pat = VEC[v].pat; samp_k = 0; mon_bad = 0; base = rise_total;
         r0 = rise_total;
         send(OP_PULSES, ARG_W'(VEC[v].n));
         idle((int'(VEC[v].n) + 1) * 2 * int'(VEC[v].half) * P + 20);
         chk_eq("R3 rising edges", rise_total - r0, int'(VEC[v].n));
         chk_eq("R3 clock parked low", int'(tgt_clk), 0);
         chk_eq("R2 high phase cycles", last_hi, int'(VEC[v].half) * P);
         chk_eq("R8 response count", samp_k, int'(VEC[v].n));
         chk_eq("R8 R10 response bit/index mismatches", mon_bad, 0);
      end

      // R4 zero count and stop
      send(OP_HALF, 16'd2);
      r0 = rise_total;
      send(OP_PULSES, 16'd0);
      idle(100);
      chk_eq("R4 zero count edges", rise_total - r0, 0);
      send(OP_RUN, 16'd0);
      idle(60);
      chk(rise_total - r0 > 3, "R2 free run edges", rise_total - r0, 4);
      send(OP_STOP, 16'd0);
      idle(20);
      r0 = rise_total;
      idle(60);
      chk_eq("R4 stop edges", rise_total - r0, 0);
      chk_eq("R4 stop level", int'(tgt_clk), 0);

      // R5 R7 R9 queued while stopped
      send(OP_EDGE, 16'd0); cur_fall = 0; dout_bad = 0;
      send(OP_RSTLVL, 16'd1);
      send(OP_DOUT, 16'd1);
      idle(40);
      chk_eq("R5 rst held while stopped", int'(tgt_rst), 0);
      chk_eq("R5 dout held while stopped", int'(tgt_dout), 0);
      send(OP_PULSES, 16'd3);
      idle(60);
      chk_eq("R7 rst level applied", int'(tgt_rst), 1);
      chk_eq("R9 dout applied", int'(tgt_dout), 1);
      chk_eq("R9 dout launched on falling edge", dout_bad, 0);
      send(OP_EDGE, 16'd1); cur_fall = 1;
      send(OP_DOUT, 16'd0);
      send(OP_PULSES, 16'd2);
      idle(50);
      chk_eq("R9 dout applied", int'(tgt_dout), 0);
      chk_eq("R9 dout launched on rising edge", dout_bad, 0);

      // R7 reset pulse
      send(OP_RUN, 16'd0);
      send(OP_RSTLVL, 16'd0);
      send(OP_RSTPULSE, 16'd3);
      idle(40);
      chk(last_rst_hi >= 2 * P + 1 && last_rst_hi <= 3 * P, "R7 pulse length", last_rst_hi, 3 * P);
      chk_eq("R7 rst low after pulse", int'(tgt_rst), 0);
      send(OP_STOP, 16'd0);
      idle(20);

      // R6 queue full
      for (int i = 0; i < QD; i++) send(OP_RSTLVL, 16'd1);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = OP_RSTLVL; cmd_arg = 16'd1;
      #1;
      chk_eq("R6 ready low when full", int'(cmd_ready), 0);
      cmd_op = OP_EDGE; cmd_arg = 16'd1;
      #1;
      chk_eq("R6 control op accepted when full", int'(cmd_ready), 1);
      @(negedge clk);
      cmd_valid = 1'b0;
      idle(10);
      chk_eq("R5 queue idle while stopped", int'(tgt_rst), 0);
      send(OP_RUN, 16'd0);
      idle(40);
      chk_eq("R6 queue drained", int'(tgt_rst), 1);
      cmd_op = OP_RSTLVL;
      #1;
      chk_eq("R6 ready after drain", int'(cmd_ready), 1);
      send(OP_STOP, 16'd0);
      idle(20);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule